// File: doc/BRIEF.md
# Simulation Harness Control Port Bank

This block sits on the I/O port bus of an 8-bit processor inside a verification environment and gives the test program running on that processor a small set of services. It claims a 32-port window (0x80 to 0x9F by default). Through it the program can flag the end of a test as passed or failed, and switch waveform capture on and off. It can send text one character at a time, to be released as a whole line when a newline arrives. It can arm a cycle watchdog with a programmable limit and request an active-low interrupt after a programmed number of clocks. It can also keep a running modulo-256 checksum and read an incrementing sequence of bytes.

Every register update happens on the clock edge that samples a write or read strobe. Read data is combinational from the address and the current register state. The simulator-side code watches the status outputs and the line strobe and does the printing, dumping and stopping.

Top module: `harness_ctrl`

## Requirements
- R1: Only addresses whose top three bits match the window base (0x80..0x9F) are decoded. Writes outside the window change no state. Reads outside the window return 0xFF. Inside the window, reads of any port other than 0x91 and 0x93 also return 0xFF.
- R2: A write to 0x80 is a command. 0x01 sets `done_pass` and 0x02 sets `done_fail`, and both stay set until reset. 0x03 sets `dump_on` and 0x04 clears it. Any other value has no effect.
- R3: Bytes written to 0x81 other than 0x0A are stored in arrival order, byte i at `line_data[8i+7:8i]`. A write of 0x0A raises `line_valid` for exactly the following cycle, with `line_len` equal to the number of stored bytes and the newline excluded, and then empties the collector.
- R4: The collector holds at most 64 bytes. Further bytes are dropped, so a long line is reported with `line_len` = 64 and its first 64 bytes.
- R5: A write to 0x82 loads the watchdog enable from bit 0. If bit 1 is set, the write also clears the watchdog count and `timeout_err`. The watchdog is enabled out of reset.
- R6: Port 0x83 holds the low byte of the 16-bit watchdog limit and 0x84 holds the high byte; the limit resets to 0xFFFF. While enabled, the count rises by one per clock. When it equals the limit, `timeout_err` is set and the count holds. `timeout_err` stays set until a write to 0x82 with bit 1 set.
- R7: Writing a nonzero N to 0x90 drives `int_n` low N clocks after the write edge. `int_n` stays low until the next write to 0x90.
- R8: Writing zero to 0x90 cancels any pending countdown and releases `int_n` high.
- R9: Port 0x91 reads and loads the checksum. Each write to 0x92 adds its byte to the checksum modulo 256.
- R10: A read of 0x93 returns the current value, and the value increments by one (wrapping) at that read's clock edge. A write to 0x93 loads a new value.
- R11: After reset, `done_pass`, `done_fail`, `dump_on`, `timeout_err` and `line_valid` are 0 and `int_n` is 1. Reads of 0x91 and 0x93 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 8 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rdata | output | 8 | Read data for the current address |
| done_pass | output | 1 | Test ended as passed |
| done_fail | output | 1 | Test ended as failed |
| dump_on | output | 1 | Waveform capture requested |
| timeout_err | output | 1 | Watchdog limit reached |
| line_valid | output | 1 | One-cycle strobe: a complete line is available |
| line_len | output | 7 | Number of bytes in the released line |
| line_data | output | 512 | Collected bytes, byte i at bits 8i+7:8i |
| int_n | output | 1 | Active-low interrupt request |

## Verification
A wrong watchdog count stays hidden until `timeout_err` rises one or more cycles too early or too late. The bench therefore runs a short limit, and it also pauses and restarts the count so that any drift shows within a few dozen clocks. A wrong countdown shows as an `int_n` edge that is off by a cycle, or as a cancel write that fails to release the line. A wrong collector fill level shows at the next newline, as a wrong `line_len` or as bytes at the wrong offsets. Checksum and sequence errors show at the next read of 0x91 or 0x93. The bench reads those ports back to back so that a lost or doubled increment is seen at once.

// File: rtl/harness_ctrl.sv
`timescale 1ns/1ps
module harness_ctrl #(
  parameter int MSG_DEPTH = 64,
  parameter logic [7:0] WIN_BASE = 8'h80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [7:0]             io_addr,
  input  logic [7:0]             io_wdata,
  input  logic                   io_rd,
  input  logic                   io_wr,
  output logic [7:0]             io_rdata,
  output logic                   done_pass,
  output logic                   done_fail,
  output logic                   dump_on,
  output logic                   timeout_err,
  output logic                   line_valid,
  output logic [6:0]             line_len,
  output logic [MSG_DEPTH*8-1:0] line_data,
  output logic                   int_n
);
  localparam int LEN_W = $clog2(MSG_DEPTH + 1);
  localparam int IDX_W = $clog2(MSG_DEPTH);
  localparam logic [LEN_W-1:0] FULL = LEN_W'(MSG_DEPTH);
  localparam logic [4:0] P_CMD = 5'h00, P_MSG = 5'h01, P_TCTL = 5'h02,
                         P_LIML = 5'h03, P_LIMH = 5'h04, P_IRQ = 5'h10,
                         P_CSUM = 5'h11, P_CADD = 5'h12, P_SEQ = 5'h13;

  logic       hit;
  logic [4:0] off;
  assign hit = io_addr[7:5] == WIN_BASE[7:5];
  assign off = io_addr[4:0];

  logic w_cmd, w_msg, w_tctl, w_liml, w_limh, w_irq, w_csum, w_cadd, w_seq, r_seq;
  assign w_cmd  = io_wr & hit & (off == P_CMD);
  assign w_msg  = io_wr & hit & (off == P_MSG);
  assign w_tctl = io_wr & hit & (off == P_TCTL);
  assign w_liml = io_wr & hit & (off == P_LIML);
  assign w_limh = io_wr & hit & (off == P_LIMH);
  assign w_irq  = io_wr & hit & (off == P_IRQ);
  assign w_csum = io_wr & hit & (off == P_CSUM);
  assign w_cadd = io_wr & hit & (off == P_CADD);
  assign w_seq  = io_wr & hit & (off == P_SEQ);
  assign r_seq  = io_rd & hit & (off == P_SEQ);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      done_pass <= 1'b0;
      done_fail <= 1'b0;
      dump_on   <= 1'b0;
    end else if (w_cmd) begin
      case (io_wdata)
        8'h01:   done_pass <= 1'b1;
        8'h02:   done_fail <= 1'b1;
        8'h03:   dump_on   <= 1'b1;
        8'h04:   dump_on   <= 1'b0;
        default: ;
      endcase
    end

  // R2
  property pass_sticky_p;
    @(posedge clk) disable iff (!rst_n) done_pass |=> done_pass;
  endproperty
  pass_sticky_chk: assert property (pass_sticky_p);

  logic [7:0]       msg_mem [MSG_DEPTH];
  logic [LEN_W-1:0] fill;
  logic             is_nl;
  assign is_nl = io_wdata == 8'h0A;

  always_ff @(posedge clk)
    if (w_msg && !is_nl && fill < FULL) msg_mem[fill[IDX_W-1:0]] <= io_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fill       <= '0;
      line_valid <= 1'b0;
      line_len   <= '0;
    end else begin
      line_valid <= 1'b0;
      if (w_msg) begin
        if (is_nl) begin
          line_valid <= 1'b1;
          line_len   <= 7'(fill);
          fill       <= '0;
        end else if (fill < FULL) begin
          fill <= fill + 1'b1;
        end
      end
    end

  for (genvar g = 0; g < MSG_DEPTH; g++) begin : g_line
    assign line_data[g*8 +: 8] = msg_mem[g];
  end

  // R4
  property len_bound_p;
    @(posedge clk) disable iff (!rst_n) line_valid |-> line_len <= 7'(MSG_DEPTH);
  endproperty
  len_bound_chk: assert property (len_bound_p);

  logic        tmo_en;
  logic [15:0] tcnt, limit;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmo_en      <= 1'b1;
      tcnt        <= '0;
      limit       <= 16'hFFFF;
      timeout_err <= 1'b0;
    end else begin
      if (w_liml) limit[7:0]  <= io_wdata;
      if (w_limh) limit[15:8] <= io_wdata;
      if (w_tctl) begin
        tmo_en <= io_wdata[0];
        if (io_wdata[1]) begin
          tcnt        <= '0;
          timeout_err <= 1'b0;
        end
      end else if (tmo_en) begin
        if (tcnt == limit) timeout_err <= 1'b1;
        else               tcnt <= tcnt + 16'd1;
      end
    end

  // R6
  property err_sticky_p;
    @(posedge clk) disable iff (!rst_n)
      timeout_err && !(w_tctl && io_wdata[1]) |=> timeout_err;
  endproperty
  err_sticky_chk: assert property (err_sticky_p);

  logic [7:0] cd;
  logic       armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cd    <= '0;
      armed <= 1'b0;
      int_n <= 1'b1;
    end else if (w_irq) begin
      cd    <= io_wdata;
      armed <= io_wdata != 8'h00;
      int_n <= 1'b1;
    end else if (armed) begin
      if (cd == 8'd1) begin
        int_n <= 1'b0;
        armed <= 1'b0;
      end else begin
        cd <= cd - 8'd1;
      end
    end

  // R7
  property int_hold_p;
    @(posedge clk) disable iff (!rst_n)
      !int_n && !(io_wr && io_addr == (WIN_BASE | 8'h10)) |=> !int_n;
  endproperty
  int_hold_chk: assert property (int_hold_p);

  logic [7:0] csum, seq;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      csum <= '0;
    else if (w_csum) csum <= io_wdata;
    else if (w_cadd) csum <= csum + io_wdata;

  // R1
  property outside_quiet_p;
    @(posedge clk) disable iff (!rst_n)
      io_wr && io_addr[7:5] != WIN_BASE[7:5] |=> $stable(csum);
  endproperty
  outside_quiet_chk: assert property (outside_quiet_p);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     seq <= '0;
    else if (w_seq) seq <= io_wdata;
    else if (r_seq) seq <= seq + 8'd1;

  // R10
  property seq_step_p;
    @(posedge clk) disable iff (!rst_n)
      io_rd && !io_wr && io_addr == (WIN_BASE | 8'h13) |=> seq == 8'($past(seq) + 8'd1);
  endproperty
  seq_step_chk: assert property (seq_step_p);

  assign io_rdata = !hit            ? 8'hFF :
                    (off == P_CSUM) ? csum  :
                    (off == P_SEQ)  ? seq   : 8'hFF;
endmodule

// File: tb/test_harness_ctrl.sv
`timescale 1ns/1ps
module test_harness_ctrl;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] io_addr = '0, io_wdata = '0;
  logic io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_rdata;
  logic done_pass, done_fail, dump_on, timeout_err, line_valid, int_n;
  logic [6:0] line_len;
  logic [DEPTH*8-1:0] line_data;

  always #5 clk = ~clk;

  harness_ctrl i_harness_ctrl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
    .done_pass(done_pass), .done_fail(done_fail), .dump_on(dump_on),
    .timeout_err(timeout_err), .line_valid(line_valid), .line_len(line_len),
    .line_data(line_data), .int_n(int_n));

  int compared = 0, mismatched = 0;
  bit finished = 0;

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  bit m_pass, m_fail, m_dump, m_en = 1, m_err, m_armed, m_intn = 1, m_lv;
  int m_cnt, m_lim = 'hFFFF, m_cd, m_csum, m_seq, m_llen;
  logic [7:0] q[$];
  logic [7:0] m_line[$];

  function automatic bit in_win(logic [7:0] a);
    return a >= 8'h80 && a <= 8'h9F;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pass = 0; m_fail = 0; m_dump = 0; m_en = 1; m_err = 0; m_cnt = 0;
      m_lim = 'hFFFF; m_armed = 0; m_cd = 0; m_intn = 1; m_csum = 0; m_seq = 0;
      m_lv = 0; m_llen = 0; q.delete();
    end else begin
      bit w, r;
      w = io_wr && in_win(io_addr);
      r = io_rd && in_win(io_addr);
      m_lv = 0;
      if (w && io_addr == 8'h82) begin
        m_en = io_wdata[0];
        if (io_wdata[1]) begin m_cnt = 0; m_err = 0; end
      end else if (m_en) begin
        if (m_cnt == m_lim) m_err = 1; else m_cnt = (m_cnt + 1) % 65536;
      end
      if (w && io_addr == 8'h83) m_lim = (m_lim & 'hFF00) | int'(io_wdata);
      if (w && io_addr == 8'h84) m_lim = (m_lim & 'h00FF) | (int'(io_wdata) << 8);
      if (w && io_addr == 8'h80) begin
        if (io_wdata == 1) m_pass = 1;
        if (io_wdata == 2) m_fail = 1;
        if (io_wdata == 3) m_dump = 1;
        if (io_wdata == 4) m_dump = 0;
      end
      if (w && io_addr == 8'h81) begin
        if (io_wdata == 8'h0A) begin
          m_lv = 1; m_llen = q.size(); m_line = q; q.delete();
        end else if (q.size() < DEPTH) q.push_back(io_wdata);
      end
      if (w && io_addr == 8'h90) begin
        m_cd = io_wdata; m_armed = io_wdata != 0; m_intn = 1;
      end else if (m_armed) begin
        if (m_cd == 1) begin m_intn = 0; m_armed = 0; end else m_cd--;
      end
      if (w && io_addr == 8'h91) m_csum = io_wdata;
      else if (w && io_addr == 8'h92) m_csum = (m_csum + io_wdata) % 256;
      if (w && io_addr == 8'h93) m_seq = io_wdata;
      else if (r && io_addr == 8'h93) m_seq = (m_seq + 1) % 256;
    end
  end

  always @(negedge clk) if (!finished) begin
    string t;
    t = rst_n ? "" : "R11 ";
    chk({t, "R2 pass"}, done_pass, m_pass);
    chk({t, "R2 fail"}, done_fail, m_fail);
    chk({t, "R2 dump"}, dump_on, m_dump);
    chk({t, "R6 timeout"}, timeout_err, m_err);
    chk({t, "R7 R8 int_n"}, int_n, m_intn);
    chk({t, "R3 line_valid"}, line_valid, m_lv);
    if (m_lv) begin
      chk(m_llen == DEPTH ? "R4 line_len" : "R3 line_len", line_len, m_llen);
      for (int i = 0; i < m_llen; i++)
        chk(m_llen == DEPTH ? "R4 byte" : "R3 byte", line_data[i*8 +: 8], m_line[i]);
    end
    if (io_rd && rst_n) begin
      int e;
      string rt;
      if (!in_win(io_addr)) begin e = 'hFF; rt = "R1 outside read"; end
      else if (io_addr == 8'h91) begin e = m_csum; rt = "R9 checksum read"; end
      else if (io_addr == 8'h93) begin e = m_seq; rt = "R10 sequence read"; end
      else begin e = 'hFF; rt = "R1 unreadable port"; end
      chk(rt, io_rdata, e);
    end
  end

  task automatic op(bit w, bit r, logic [7:0] a, logic [7:0] d);
    io_wr = w; io_rd = r; io_addr = a; io_wdata = d;
    @(posedge clk); #2;
    io_wr = 0; io_rd = 0;
  endtask
  task automatic wr(logic [7:0] a, logic [7:0] d); op(1, 0, a, d); endtask
  task automatic rd(logic [7:0] a); op(0, 1, a, 8'h00); endtask
  task automatic idle(int n); repeat (n) begin @(posedge clk); #2; end endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    idle(2);
    rd(8'h91); rd(8'h93);                       // R11
    wr(8'h12, 8'h55); wr(8'hA0, 8'h01);         // R1 outside writes
    wr(8'h11, 8'h02); wr(8'h12, 8'h03); wr(8'hB1, 8'h77); wr(8'h72, 8'h03);
    rd(8'h12); rd(8'hB1); rd(8'h91); rd(8'h85); rd(8'h92); rd(8'h80);
    wr(8'h80, 8'h03); wr(8'h80, 8'h07); wr(8'h80, 8'h04); wr(8'h80, 8'h03);   // R2
    wr(8'h80, 8'h00); wr(8'h80, 8'h01); idle(2); wr(8'h80, 8'h02); idle(2);
    wr(8'h81, "H"); wr(8'h81, "I"); wr(8'h81, "!"); wr(8'h81, 8'h0A);        // R3
    wr(8'h81, 8'h0A); wr(8'h81, "z"); wr(8'h81, 8'h0A); idle(2);
    for (int k = 0; k < 70; k++) wr(8'h81, 8'(8'h30 + k));                   // R4
    wr(8'h81, 8'h0A); wr(8'h81, "a"); wr(8'h81, 8'h0A); idle(2);
    wr(8'h82, 8'h00); idle(3);                                              // R5
    wr(8'h84, 8'h00); wr(8'h83, 8'h0A); wr(8'h82, 8'h03); idle(20);         // R6
    wr(8'h82, 8'h02); idle(5); wr(8'h82, 8'h01); idle(6);
    wr(8'h82, 8'h00); idle(4); wr(8'h82, 8'h01); idle(12);
    wr(8'h83, 8'h04); wr(8'h82, 8'h03); idle(10); wr(8'h82, 8'h02); idle(2);
    wr(8'h90, 8'h05); idle(10);                                             // R7
    wr(8'h90, 8'h03); idle(1); wr(8'h90, 8'h00); idle(6);                   // R8
    wr(8'h90, 8'h01); idle(3); wr(8'h90, 8'h02); wr(8'h90, 8'h00); idle(4);
    wr(8'h91, 8'hF0); rd(8'h91); wr(8'h92, 8'h20); wr(8'h92, 8'hFF);        // R9
    rd(8'h91); rd(8'h92); wr(8'h92, 8'h01); rd(8'h91);
    wr(8'h93, 8'hFE); rd(8'h93); rd(8'h93); rd(8'h93); rd(8'h93);           // R10
    wr(8'h93, 8'h10); idle(1); rd(8'h93); rd(8'h93);
    idle(3);
    summary();
  end
endmodule